// File: doc/BRIEF.md
# Prescaled Interval Timer With Interrupt

This block is a down-counting interval timer for a small peripheral device that also carries RAM and I/O ports. A write loads an 8-bit count. The same write picks one of four clock prescale ratios through its low address bits. The count falls by one at the selected rate.

When the count steps below zero, a timer flag is raised and counting drops to one step per clock, starting again from all ones. The next timer access returns the programmed prescale ratio. A read of the count returns the prescaled value.

The block also holds the shared interrupt status. A second flag is set by a pulse from the port block's edge detector. One registered, active-high interrupt line combines the two flags with their enables. Edge-control writes are not decoded here: they are flagged on a strobe so the port block can take them.

Top module: `intv_timer`

## Requirements
- R1: A write with cs=1, we=1, addr[2]=1 and addr[4]=1 loads the count with wdata. The prescale is taken from addr[1:0]: 00 gives divide-by-1, 01 divide-by-8, 10 divide-by-64 and 11 divide-by-1024. The count drops by one every ratio clocks. The first drop falls on the clock after the load.
- R2: A timer load or a timer read copies addr[3] into the timer interrupt enable. With the enable set, a raised timer flag drives irq high.
- R3: A timer read is cs=1, we=0, addr[2]=1 and addr[0]=0. It returns the current prescaled count on rdata in the same cycle. It clears the timer flag at the clock edge. A load also clears the timer flag.
- R4: Reaching a count of zero sets no flag. The step below zero sets the timer flag. The count becomes 0xFF and then drops once per clock. If a read clears the flag in the same cycle as this step, the flag still ends up set.
- R5: While the divide-by-1 state left by an underflow is in force, a timer read returns the count and then restores the last loaded prescale. The new state keeps the count and fills the prescaler with all ones, so the next drop of the count comes after the full ratio.
- R6: A status read is cs=1, we=0, addr[2]=1 and addr[0]=1. It returns the timer flag in bit 7 and the edge flag in bit 6, with bits 5 to 0 zero. It clears only the edge flag. A pulse on edge_set sets the edge flag, and it wins over a status read in the same cycle.
- R7: irq is registered. It equals (timer flag AND timer enable) OR (edge flag AND edge_irq_en), taken one clock earlier.
- R8: A write with addr[2]=1 and addr[4]=0 raises edge_cfg_we during that cycle and leaves the timer untouched.
- R9: After reset the flags, the timer enable and irq are 0. The prescale is divide-by-1024 and the count reads 0xFF.
- R10: An access with addr[2]=0, or a cycle with no read, returns rdata=0 and changes no state of the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs | input | 1 | Chip select for a bus access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 5 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| edge_set | input | 1 | One-clock pulse from the port edge detector |
| edge_irq_en | input | 1 | Edge interrupt enable held by the port block |
| edge_cfg_we | output | 1 | Strobe for an edge-control write |
| irq | output | 1 | Interrupt request, active high, registered |

## Verification
Damage to the prescaler residue or to the forced divide-by-1 state shows on the next timer read. The count comes back one step early or late. After an underflow, the restore lands at the wrong rate, which shows within one prescale period. A flag that sets, clears or survives wrongly shows on irq one clock later when its enable is on. It also shows on the next status read. A reference model runs in step with the design on every clock, so a divergence is reported in the cycle it first reaches a port.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

   typedef struct packed {
      logic load;
      logic tread;
      logic sread;
      logic ecfg;
   } itmr_acc_t;

endpackage

// File: rtl/itmr_decode.sv
module itmr_decode
   import itmr_pkg::*;
#(
   parameter int ADDR_W   = 5,
   parameter int GRP_BIT  = 2,
   parameter int LOAD_BIT = 4,
   parameter int STAT_BIT = 0
) (
   input  logic              cs,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   output itmr_acc_t         acc
);
   generate
      if (GRP_BIT >= ADDR_W || LOAD_BIT >= ADDR_W || STAT_BIT >= ADDR_W) begin : g_bad_bits
         $error("itmr_decode: decode bit outside address");
      end
   endgenerate

   logic in_grp;
   assign in_grp    = cs && addr[GRP_BIT];
   assign acc.load  = in_grp && we && addr[LOAD_BIT];
   assign acc.ecfg  = in_grp && we && !addr[LOAD_BIT];
   assign acc.tread = in_grp && !we && !addr[STAT_BIT];
   assign acc.sread = in_grp && !we && addr[STAT_BIT];
endmodule

// File: rtl/itmr_count.sv
module itmr_count #(
   parameter int CNT_W = 8,
   parameter int SH_1  = 3,
   parameter int SH_2  = 6,
   parameter int SH_3  = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld,
   input  logic             tread,
   input  logic [1:0]       sel_i,
   input  logic [CNT_W-1:0] data_i,
   output logic [CNT_W-1:0] count_o,
   output logic             uf_o
);
   localparam int VAL_W = CNT_W + SH_3;

   generate
      if (!(SH_1 > 0 && SH_1 < SH_2 && SH_2 < SH_3)) begin : g_bad_shift
         $error("itmr_count: prescale shifts must rise strictly");
      end
   endgenerate

   function automatic int unsigned shift_of(input logic [1:0] s);
      case (s)
         2'd0:    return 0;
         2'd1:    return SH_1;
         2'd2:    return SH_2;
         default: return SH_3;
      endcase
   endfunction

   logic [VAL_W-1:0] val_q, base, val_d;
   logic [1:0]       sel_q;
   logic             fast_q, restore;
   int unsigned      act_sh, wr_sh;

   assign wr_sh   = shift_of(sel_q);
   assign act_sh  = fast_q ? 0 : wr_sh;
   assign count_o = CNT_W'(val_q >> act_sh);
   assign restore = tread && fast_q;

   always_comb begin
      base = val_q;
      if (restore) base = (val_q << wr_sh) | ((VAL_W'(1) << wr_sh) - VAL_W'(1));
      uf_o = !ld && (base == '0);
      if (ld)        val_d = VAL_W'(data_i) << shift_of(sel_i);
      else if (uf_o) val_d = VAL_W'({CNT_W{1'b1}});
      else           val_d = base - VAL_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         val_q  <= VAL_W'({CNT_W{1'b1}}) << SH_3;
         sel_q  <= 2'd3;
         fast_q <= 1'b0;
      end else begin
         val_q <= val_d;
         if (ld) begin
            sel_q  <= sel_i;
            fast_q <= 1'b0;
         end else if (uf_o) begin
            fast_q <= 1'b1;
         end else if (restore) begin
            fast_q <= 1'b0;
         end
      end
   end

   p_load_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (count_o == $past(data_i)));
   p_uf_to_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
      uf_o |=> (count_o == {CNT_W{1'b1}}));
endmodule

// File: rtl/itmr_flags.sv
module itmr_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic ld,
   input  logic tread,
   input  logic sread,
   input  logic ten_bit,
   input  logic uf,
   input  logic edge_set,
   input  logic edge_en,
   output logic tflag_o,
   output logic eflag_o,
   output logic irq_o
);
   logic tflag_q, eflag_q, ten_q, irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tflag_q <= 1'b0;
         eflag_q <= 1'b0;
         ten_q   <= 1'b0;
         irq_q   <= 1'b0;
      end else begin
         irq_q <= (tflag_q && ten_q) || (eflag_q && edge_en);
         if (uf)                tflag_q <= 1'b1;
         else if (ld || tread)  tflag_q <= 1'b0;
         if (ld || tread)       ten_q   <= ten_bit;
         if (edge_set)          eflag_q <= 1'b1;
         else if (sread)        eflag_q <= 1'b0;
      end
   end

   assign tflag_o = tflag_q;
   assign eflag_o = eflag_q;
   assign irq_o   = irq_q;

   p_uf_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      uf |=> tflag_q);
   p_stat_clears_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sread && !edge_set) |=> !eflag_q);
   p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!tflag_q && !eflag_q) |=> !irq_q);
endmodule

// File: rtl/intv_timer.sv
module intv_timer
   import itmr_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int CNT_W  = 8,
   parameter int SH_1   = 3,
   parameter int SH_2   = 6,
   parameter int SH_3   = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CNT_W-1:0]  wdata,
   output logic [CNT_W-1:0]  rdata,
   input  logic              edge_set,
   input  logic              edge_irq_en,
   output logic              edge_cfg_we,
   output logic              irq
);
   localparam int EN_BIT = 3;

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("intv_timer: count too narrow for status bits");
      end
   endgenerate

   itmr_acc_t        acc;
   logic [CNT_W-1:0] count;
   logic             uf, tflag, eflag;

   itmr_decode #(.ADDR_W(ADDR_W)) u_dec (
      .cs(cs), .we(we), .addr(addr), .acc(acc)
   );

   itmr_count #(.CNT_W(CNT_W), .SH_1(SH_1), .SH_2(SH_2), .SH_3(SH_3)) u_cnt (
      .clk(clk), .rst_n(rst_n), .ld(acc.load), .tread(acc.tread),
      .sel_i(addr[1:0]), .data_i(wdata), .count_o(count), .uf_o(uf)
   );

   itmr_flags u_flg (
      .clk(clk), .rst_n(rst_n), .ld(acc.load), .tread(acc.tread),
      .sread(acc.sread), .ten_bit(addr[EN_BIT]), .uf(uf),
      .edge_set(edge_set), .edge_en(edge_irq_en),
      .tflag_o(tflag), .eflag_o(eflag), .irq_o(irq)
   );

   always_comb begin
      rdata = '0;
      if (acc.tread)      rdata = count;
      else if (acc.sread) rdata = {tflag, eflag, {(CNT_W-2){1'b0}}};
   end

   assign edge_cfg_we = acc.ecfg;

   always_comb begin
      if (rst_n && acc.sread)
         p_stat_low_zero_r6: assert (rdata[CNT_W-3:0] == '0);
   end
endmodule

// File: tb/intv_timer_tb.sv
`timescale 1ns/100ps
module intv_timer_tb;
   logic       clk = 1'b0, rst_n = 1'b0;
   logic       cs = 0, we = 0, edge_set = 0, edge_en = 0;
   logic [4:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       ecfg, irq;

   int total = 0, bad = 0, cycles = 0;
   bit done = 0;
   string rtag = "";
   int m_val, m_sel, m_fast, m_tf, m_ten, m_ef, m_irq;

   always #2.5 clk = ~clk;

   intv_timer u_dut (
      .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
      .rdata(rdata), .edge_set(edge_set), .edge_irq_en(edge_en),
      .edge_cfg_we(ecfg), .irq(irq)
   );

   function automatic int shf(input int s);
      case (s)
         0: return 0;
         1: return 3;
         2: return 6;
         default: return 10;
      endcase
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cycles);
      end
   endtask

   task automatic tick();
      bit tr, sr, ld, ec;
      int sh, exp_rd, nirq, base;
      #1;
      tr = cs && addr[2] && !we && !addr[0];
      sr = cs && addr[2] && !we && addr[0];
      ld = cs && addr[2] && we && addr[4];
      ec = cs && addr[2] && we && !addr[4];
      sh = m_fast ? 0 : shf(m_sel);
      exp_rd = tr ? ((m_val >> sh) & 255) : sr ? (m_tf * 128 + m_ef * 64) : 0;
      chk(tr ? (rtag != "" ? rtag : "R3") : sr ? "R6" : "R10", int'(rdata), exp_rd);
      chk("R7", int'(irq), m_irq);
      chk("R8", int'(ecfg), int'(ec));
      @(posedge clk);
      nirq = ((m_tf && m_ten) || (m_ef && edge_en)) ? 1 : 0;
      if (ld) begin
         m_sel = addr[1:0]; m_fast = 0; m_val = int'(wdata) << shf(m_sel);
         m_ten = addr[3]; m_tf = 0;
      end else begin
         base = m_val;
         if (tr) begin
            m_ten = addr[3]; m_tf = 0;
            if (m_fast) begin
               base = (m_val << shf(m_sel)) | ((1 << shf(m_sel)) - 1);
               m_fast = 0;
            end
         end
         if (base == 0) begin m_val = 255; m_fast = 1; m_tf = 1; end
         else m_val = base - 1;
      end
      if (edge_set) m_ef = 1; else if (sr) m_ef = 0;
      m_irq = nirq;
      @(negedge clk);
      cycles++;
   endtask

   task automatic idle(input int n);
      cs = 0; we = 0;
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic acc(input bit w, input logic [4:0] a, input logic [7:0] d);
      cs = 1; we = w; addr = a; wdata = d;
      tick();
      cs = 0; we = 0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      m_val = 255 << 10; m_sel = 3; m_fast = 0;
      m_tf = 0; m_ten = 0; m_ef = 0; m_irq = 0;
      // R9: reset state
      chk("R9", int'(irq), 0);
      rtag = "R9"; acc(0, 5'h04, 0);
      acc(0, 5'h05, 0);
      chk("R9", int'(irq), 0);
      // R1: loads at each ratio
      rtag = "R1"; acc(1, 5'h14, 8'd5);
      for (int i = 0; i < 4; i++) acc(0, 5'h04, 0);
      acc(1, 5'h15, 8'd3);
      for (int i = 0; i < 12; i++) begin acc(0, 5'h04, 0); idle(2); end
      acc(1, 5'h16, 8'd2);
      for (int i = 0; i < 5; i++) begin acc(0, 5'h04, 0); idle(40); end
      acc(1, 5'h17, 8'd1);
      for (int i = 0; i < 6; i++) begin idle(500); acc(0, 5'h04, 0); end
      // R4: count to zero then through it
      rtag = "R4"; acc(1, 5'h14, 8'd2);
      for (int i = 0; i < 6; i++) acc(0, 5'h04, 0);
      // R5: restore of written prescale after underflow
      rtag = "R5"; acc(1, 5'h1D, 8'd1);
      idle(20);
      acc(0, 5'h0C, 0);
      for (int i = 0; i < 6; i++) begin idle(3); acc(0, 5'h0C, 0); end
      acc(1, 5'h1E, 8'd0);
      idle(70);
      acc(0, 5'h0C, 0);
      idle(64); acc(0, 5'h0C, 0);
      // R2: timer enable from address bit 3
      rtag = "R2"; acc(1, 5'h1C, 8'd0);
      idle(3);
      chk("R2", int'(irq), 1);
      acc(0, 5'h04, 0);
      idle(2);
      chk("R2", int'(irq), 0);
      // R6 / R7: edge flag and shared status
      rtag = "";
      acc(1, 5'h17, 8'd200);
      edge_en = 1; edge_set = 1; tick(); edge_set = 0;
      idle(2);
      chk("R7", int'(irq), 1);
      acc(0, 5'h05, 0);
      idle(2);
      chk("R6", int'(irq), 0);
      edge_set = 1; cs = 1; addr = 5'h05; tick(); edge_set = 0; cs = 0;
      acc(0, 5'h05, 0);
      acc(0, 5'h07, 0);
      edge_en = 0; edge_set = 1; tick(); edge_set = 0;
      idle(3);
      acc(0, 5'h05, 0);
      // R8: edge-control write does not touch the timer
      acc(1, 5'h06, 8'hA5);
      acc(1, 5'h07, 8'h00);
      acc(0, 5'h04, 0);
      // R10: outside the group
      acc(1, 5'h10, 8'h01); acc(1, 5'h1B, 8'h02); acc(0, 5'h18, 0); acc(0, 5'h01, 0);
      acc(0, 5'h04, 0);
      // mixed traffic
      edge_en = 1;
      for (int i = 0; i < 3000; i++) begin
         cs = ($urandom_range(0, 3) == 0);
         we = $urandom_range(0, 1);
         addr = 5'($urandom_range(0, 31));
         wdata = 8'($urandom_range(0, 6));
         edge_set = ($urandom_range(0, 15) == 0);
         edge_en = ($urandom_range(0, 7) != 0);
         tick();
      end
      cs = 0; edge_set = 0;
      idle(4);
      finish_run();
   end
endmodule